// File: doc/BRIEF.md
# Vectored Interrupt Controller with Edge Select

This block gathers interrupt requests for a small microcontroller core and turns them into a single vectored call request. Five sources feed it:

- an external pin with a selectable trigger edge,
- a pulse that marks the end of a non-volatile memory write,
- a timer overflow pulse,
- four serial-bus event pulses that share one source,
- a time-base tick.

Each source latches into its own request flag. Each source has its own enable bit and its own fixed vector address.

A call is raised when four things hold together: the global enable is set, a source is both enabled and flagged, the core reports room on its call stack, and no earlier call is still waiting for its acknowledge. The call is a one-cycle pulse. The vector stays on `call_vec` until the core acknowledges. On the acknowledge the block clears the serviced flag and the global enable in hardware. Every other source then stays blocked until software sets the global enable again.

Software sets or clears the global enable with strobes, and it can clear any request flag directly with a strobe.

Top module: `irqv_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, all request flags, `gie_out`, `call_req` and `call_vec` are zero.
- R2: The edge-select input `ext_edge_sel` chooses the pin trigger: 2'b00 never triggers, 2'b01 triggers on a low-to-high change, 2'b10 on a high-to-low change, 2'b11 on either change. The pin passes through a two-flop synchronizer, and its flag appears within five cycles of the change.
- R3: The external flag (bit 0) is set only when three inputs are high together: `src_en[0]`, `ext_route_en` and `ext_dir_in`. A pin edge seen while any of them is low leaves the flag clear.
- R4: Each of the other sources sets its own flag whether or not its enable is set: `ee_write_done` sets bit 1, `tmr_overflow` sets bit 2, `tbase_tick` sets bit 4, and any of `ser_rx_done`, `ser_tx_done`, `ser_addr_hit` or `ser_timeout` sets bit 3.
- R5: A call is raised only when all of these hold: the global enable is set, a source's enable and flag are both set, `stack_full` is low, and no earlier call is waiting for `svc_ack`. A pending flag whose enable is clear, or that is held off by `stack_full`, stays set and is taken once the blocking condition ends.
- R6: `call_req` is high for exactly one cycle per call. `call_vec` carries the vector from that cycle and holds it unchanged until `svc_ack`.
- R7: The vectors are 0x04 for the external pin, 0x08 for the write end, 0x0C for the timer, 0x10 for the serial interface and 0x14 for the time base.
- R8: When several eligible requests are pending at once, the one with the lowest vector address is called first.
- R9: `svc_ack` while a call is outstanding clears the serviced source's flag and the global enable at that clock edge. The other flags are left unchanged.
- R10: A high bit of `flag_clr` clears that flag. A source event in the same cycle as any clear of its flag leaves the flag set.
- R11: `gie_set` sets the global enable, and `gie_clr` clears it. `gie_clr` or an acknowledge in the same cycle as `gie_set` leaves the global enable clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| ext_edge_sel | input | 2 | Pin trigger select (R2 encoding) |
| ext_route_en | input | 1 | Pin function is routed to the interrupt |
| ext_dir_in | input | 1 | Pin is configured as an input |
| ee_write_done | input | 1 | Non-volatile write cycle finished pulse |
| tmr_overflow | input | 1 | Timer overflow pulse |
| ser_rx_done | input | 1 | Serial byte received pulse |
| ser_tx_done | input | 1 | Serial byte transmitted pulse |
| ser_addr_hit | input | 1 | Serial slave address match pulse |
| ser_timeout | input | 1 | Serial bus time-out pulse |
| tbase_tick | input | 1 | Time-base tick pulse |
| src_en | input | 5 | Per-source enable, bit order as in R4 |
| flag_clr | input | 5 | Per-flag software clear strobe |
| gie_set | input | 1 | Global enable set strobe |
| gie_clr | input | 1 | Global enable clear strobe |
| stack_full | input | 1 | Core call stack has no free entry |
| svc_ack | input | 1 | Core has taken the outstanding call |
| call_req | output | 1 | One-cycle call request |
| call_vec | output | 8 | Vector address of the call |
| flags_out | output | 5 | Current request flags |
| gie_out | output | 1 | Current global enable |

## Verification
The hardest situations to reach are the same-cycle collisions at the acknowledge edge. In one, a new event on the serviced source lands in the same cycle as `svc_ack`. In another, software sets the global enable in that same cycle. Either way the outcome depends on which update wins inside a single edge.

The bench reaches these by parking a call in its waiting state. It then drives the acknowledge together with the colliding strobe or source pulse on one falling edge. It also fills several flags while the global enable is off, so that one `gie_set` exposes the priority order. It walks the pin through all four edge modes with the synchronizer allowed to settle between changes.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  // Number of interrupt sources and index width
  localparam int NSRC  = 5;
  localparam int SRC_W = $clog2(NSRC);

  // Source index order; this order is also the priority order
  typedef enum logic [SRC_W-1:0] {
    SRC_EXT = 3'd0,
    SRC_EE  = 3'd1,
    SRC_TMR = 3'd2,
    SRC_SER = 3'd3,
    SRC_TB  = 3'd4
  } src_e;

  // Pin trigger modes: bit 0 arms rising, bit 1 arms falling
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  // Vector arithmetic: base plus a fixed stride per source index
  function automatic int vec_addr(input int base, input int step, input int idx);
    return base + step * idx;
  endfunction
endpackage

// File: rtl/irqv_pin_edge.sv
module irqv_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic [1:0] mode_i,
  input  logic       arm_i,
  output logic       hit_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   pin_s;
  logic                   rise_w;
  logic                   fall_w;

  // Synchronizer chain; the last stage is the settled pin level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= sync_q[MSB];
    end
  end

  assign pin_s  = sync_q[MSB];
  assign rise_w = pin_s & ~prev_q;
  assign fall_w = ~pin_s & prev_q;

  always_comb begin
    hit_o = 1'b0;
    if (arm_i) begin
      unique case (irqv_pkg::edge_mode_e'(mode_i))
        irqv_pkg::EDGE_OFF:  hit_o = 1'b0;
        irqv_pkg::EDGE_RISE: hit_o = rise_w;
        irqv_pkg::EDGE_FALL: hit_o = fall_w;
        irqv_pkg::EDGE_BOTH: hit_o = rise_w | fall_w;
        default:             hit_o = 1'b0;
      endcase
    end
  end

  // R2: a hit is only ever reported when the settled level just moved
  p_hit_on_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (pin_s != prev_q));

  // R2: mode 00 keeps the pin silent
  p_off_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b00) |-> !hit_o);

  // R3: a disarmed pin never reports
  p_disarmed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_i |-> !hit_o);
endmodule

// File: rtl/irqv_flag_bank.sv
module irqv_flag_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    logic q;

    // A set beats a clear so that no event is lost
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q <= 1'b0;
      else if (set_i[k])   q <= 1'b1;
      else if (clr_i[k])   q <= 1'b0;
    end

    assign flags_o[k] = q;

    // R10: an event always leaves its flag set
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[k] |=> flags_o[k]);

    // R9 / R10: a clear without an event empties the flag
    p_clear_takes_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[k] && !set_i[k]) |=> !flags_o[k]);

    // R5: without set or clear the flag keeps its value
    p_flag_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i[k] && !set_i[k]) |=> $stable(flags_o[k]));
  end
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter #(
  parameter int N        = 5,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4,
  localparam int IDX_W   = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [N-1:0]     grant_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [VEC_W-1:0] vec_o
);
  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    return VEC_W'(irqv_pkg::vec_addr(VEC_BASE, VEC_STEP, int'(idx)));
  endfunction

  // Scan from the top so that the lowest index is the last one written
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(k);
      end
    end
    grant_o = any_o ? (N'(1) << idx_o) : '0;
    vec_o   = vec_of(idx_o);
  end
endmodule

// File: rtl/irqv_ctrl.sv
module irqv_ctrl #(
  parameter int VEC_W       = 8,
  parameter int VEC_BASE    = 4,
  parameter int VEC_STEP    = 4,
  parameter int SYNC_STAGES = 2   // two or more
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ext_pin,
  input  logic [1:0]                ext_edge_sel,
  input  logic                      ext_route_en,
  input  logic                      ext_dir_in,
  input  logic                      ee_write_done,
  input  logic                      tmr_overflow,
  input  logic                      ser_rx_done,
  input  logic                      ser_tx_done,
  input  logic                      ser_addr_hit,
  input  logic                      ser_timeout,
  input  logic                      tbase_tick,
  input  logic [irqv_pkg::NSRC-1:0] src_en,
  input  logic [irqv_pkg::NSRC-1:0] flag_clr,
  input  logic                      gie_set,
  input  logic                      gie_clr,
  input  logic                      stack_full,
  input  logic                      svc_ack,
  output logic                      call_req,
  output logic [VEC_W-1:0]          call_vec,
  output logic [irqv_pkg::NSRC-1:0] flags_out,
  output logic                      gie_out
);
  import irqv_pkg::*;

  localparam int N = NSRC;
  localparam int W = SRC_W;

  // Named internal events
  logic         ext_arm;
  logic         ext_hit;
  logic         ser_event;
  logic [N-1:0] set_vec;
  logic [N-1:0] clr_vec;
  logic [N-1:0] ack_clr;
  logic [N-1:0] flags;
  logic [N-1:0] eligible;
  logic         arb_any;
  logic [N-1:0] arb_grant;
  logic [W-1:0] arb_idx;
  logic [VEC_W-1:0] arb_vec;
  logic         take;
  logic         ack_fire;

  // Registered state
  logic             busy_q;
  logic [W-1:0]     cur_q;
  logic             call_q;
  logic [VEC_W-1:0] vec_q;
  logic             gie_q;

  // External pin path
  assign ext_arm = src_en[SRC_EXT] & ext_route_en & ext_dir_in;

  irqv_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (ext_pin),
    .mode_i (ext_edge_sel),
    .arm_i  (ext_arm),
    .hit_o  (ext_hit)
  );

  // Source events into flag positions
  assign ser_event = ser_rx_done | ser_tx_done | ser_addr_hit | ser_timeout;

  always_comb begin
    set_vec          = '0;
    set_vec[SRC_EXT] = ext_hit;
    set_vec[SRC_EE]  = ee_write_done;
    set_vec[SRC_TMR] = tmr_overflow;
    set_vec[SRC_SER] = ser_event;
    set_vec[SRC_TB]  = tbase_tick;
  end

  assign ack_fire = busy_q & svc_ack;
  assign ack_clr  = ack_fire ? (N'(1) << cur_q) : '0;
  assign clr_vec  = flag_clr | ack_clr;

  irqv_flag_bank #(.N(N)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (set_vec),
    .clr_i   (clr_vec),
    .flags_o (flags)
  );

  // Dispatch gate
  assign eligible = flags & src_en & {N{gie_q & ~stack_full & ~busy_q}};

  irqv_arbiter #(
    .N        (N),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
  ) u_arb (
    .req_i   (eligible),
    .any_o   (arb_any),
    .grant_o (arb_grant),
    .idx_o   (arb_idx),
    .vec_o   (arb_vec)
  );

  assign take = arb_any;

  // Call and wait state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      call_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      call_q <= take;
      if (take) begin
        busy_q <= 1'b1;
        cur_q  <= arb_idx;
        vec_q  <= arb_vec;
      end else if (ack_fire) begin
        busy_q <= 1'b0;
        vec_q  <= '0;
      end
    end
  end

  // Global enable: any clear beats a set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   gie_q <= 1'b0;
    else if (ack_fire || gie_clr) gie_q <= 1'b0;
    else if (gie_set)             gie_q <= 1'b1;
  end

  assign call_req  = call_q;
  assign call_vec  = vec_q;
  assign flags_out = flags;
  assign gie_out   = gie_q;

  // R6: call request lasts one cycle
  p_call_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |=> !call_req);

  // R6: vector holds while the call waits
  p_vec_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !svc_ack) |=> $stable(call_vec));

  // R5: a call follows only an enabled, unblocked cycle
  p_call_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> ($past(gie_q) && !$past(stack_full) && !$past(busy_q)));

  // R9: acknowledge drops the global enable
  p_ack_drops_gie_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> !gie_q);

  // R8: at most one grant, and never above a lower pending request
  p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(arb_grant));

  p_grant_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arb_any |-> (((arb_grant - N'(1)) & eligible) == '0));
endmodule

// File: tb/irqv_ctrl_tb.sv
`timescale 1ns/1ps
module irqv_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ext_pin, ext_route_en, ext_dir_in;
  logic [1:0] ext_edge_sel;
  logic       ee_write_done, tmr_overflow, tbase_tick;
  logic       ser_rx_done, ser_tx_done, ser_addr_hit, ser_timeout;
  logic [4:0] src_en, flag_clr;
  logic       gie_set, gie_clr, stack_full, svc_ack;
  logic       call_req;
  logic [7:0] call_vec;
  logic [4:0] flags_out;
  logic       gie_out;

  int n_checks = 0;
  int n_fail   = 0;
  int call_cnt = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  irqv_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_edge_sel(ext_edge_sel),
    .ext_route_en(ext_route_en), .ext_dir_in(ext_dir_in),
    .ee_write_done(ee_write_done), .tmr_overflow(tmr_overflow),
    .ser_rx_done(ser_rx_done), .ser_tx_done(ser_tx_done),
    .ser_addr_hit(ser_addr_hit), .ser_timeout(ser_timeout),
    .tbase_tick(tbase_tick), .src_en(src_en), .flag_clr(flag_clr),
    .gie_set(gie_set), .gie_clr(gie_clr), .stack_full(stack_full),
    .svc_ack(svc_ack), .call_req(call_req), .call_vec(call_vec),
    .flags_out(flags_out), .gie_out(gie_out)
  );

  always @(negedge clk) if (rst_n && call_req) call_cnt++;

  function automatic logic [7:0] exp_vec(input int src);
    return 8'(4 * (src + 1));
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_src(input int src);
    @(negedge clk);
    case (src)
      1: ee_write_done = 1'b1;
      2: tmr_overflow  = 1'b1;
      3: ser_rx_done   = 1'b1;
      4: tbase_tick    = 1'b1;
      default: ;
    endcase
    @(negedge clk);
    ee_write_done = 0; tmr_overflow = 0; ser_rx_done = 0; tbase_tick = 0;
  endtask

  task automatic strobe_gie_set();
    @(negedge clk); gie_set = 1'b1;
    @(negedge clk); gie_set = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk); svc_ack = 1'b1;
    @(negedge clk); svc_ack = 1'b0;
  endtask

  task automatic clear_all();
    @(negedge clk); flag_clr = 5'h1f;
    @(negedge clk); flag_clr = 5'h00;
  endtask

  task automatic wait_call(input int maxc, output bit seen,
                           output logic [7:0] v, output int width);
    seen = 0; v = '0; width = 0;
    for (int c = 0; c < maxc && !seen; c++) begin
      @(negedge clk);
      if (call_req) begin seen = 1; v = call_vec; end
    end
    if (seen) begin
      width = 1;
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        if (call_req) width++;
      end
    end
  endtask

  task automatic set_pin(input logic lvl);
    @(negedge clk); ext_pin = lvl;
    tick(5);
  endtask

  // R1
  task automatic t_reset();
    check("R1", "flags", flags_out, 5'h00);
    check("R1", "gie", gie_out, 1'b0);
    check("R1", "call_req", call_req, 1'b0);
    check("R1", "call_vec", call_vec, 8'h00);
  endtask

  // R4 R5 R6 R7 R9
  task automatic t_timer_call();
    bit s; logic [7:0] v; int w;
    src_en = 5'h1f;
    strobe_gie_set();
    pulse_src(2);
    wait_call(10, s, v, w);
    check("R5", "timer call seen", s, 1'b1);
    check("R7", "timer vector", v, exp_vec(2));
    check("R6", "pulse width", w, 1);
    check("R6", "vector held", call_vec, exp_vec(2));
    check("R4", "timer flag set", flags_out[2], 1'b1);
    do_ack();
    check("R9", "timer flag cleared", flags_out[2], 1'b0);
    check("R9", "gie cleared", gie_out, 1'b0);
  endtask

  // R7 over every source
  task automatic t_vectors();
    bit s; logic [7:0] v; int w;
    src_en = 5'h1f; ext_route_en = 1; ext_dir_in = 1; ext_edge_sel = 2'b01;
    set_pin(1'b1);
    strobe_gie_set();
    wait_call(10, s, v, w);
    check("R7", "ext vector", v, exp_vec(0));
    do_ack();
    set_pin(1'b0);
    for (int k = 1; k < 5; k++) begin
      pulse_src(k);
      strobe_gie_set();
      wait_call(10, s, v, w);
      check("R7", $sformatf("vector src %0d", k), v, exp_vec(k));
      do_ack();
    end
    check("R7", "flags empty", flags_out, 5'h00);
  endtask

  // R8 R9
  task automatic t_priority();
    bit s; logic [7:0] v; int w;
    src_en = 5'h1f;
    pulse_src(4); pulse_src(3); pulse_src(1);
    check("R8", "three flags", flags_out, 5'b11010);
    strobe_gie_set();
    wait_call(10, s, v, w);
    check("R8", "first wins", v, exp_vec(1));
    do_ack();
    check("R9", "others kept", flags_out, 5'b11000);
    strobe_gie_set();
    wait_call(10, s, v, w);
    check("R8", "second", v, exp_vec(3));
    do_ack();
    strobe_gie_set();
    wait_call(10, s, v, w);
    check("R8", "third", v, exp_vec(4));
    do_ack();
  endtask

  // R5 stack full and disabled source
  task automatic t_holdoff();
    bit s; logic [7:0] v; int w;
    src_en = 5'h1f; stack_full = 1;
    pulse_src(2);
    strobe_gie_set();
    wait_call(10, s, v, w);
    check("R5", "stack full blocks", s, 1'b0);
    check("R5", "flag kept while full", flags_out[2], 1'b1);
    @(negedge clk); stack_full = 0;
    wait_call(10, s, v, w);
    check("R5", "taken after full drops", v, exp_vec(2));
    do_ack();
    src_en = 5'h1d;
    pulse_src(1);
    strobe_gie_set();
    wait_call(8, s, v, w);
    check("R5", "disabled blocks", s, 1'b0);
    check("R5", "flag kept while disabled", flags_out[1], 1'b1);
    @(negedge clk); src_en = 5'h1f;
    wait_call(10, s, v, w);
    check("R5", "taken after enable", v, exp_vec(1));
    do_ack();
  endtask

  // R5 no second call while waiting
  task automatic t_busy();
    bit s; logic [7:0] v; int w; int c0;
    src_en = 5'h1f;
    pulse_src(4); pulse_src(2);
    strobe_gie_set();
    wait_call(10, s, v, w);
    c0 = call_cnt;
    tick(6);
    check("R5", "no call while waiting", call_cnt - c0, 0);
    check("R6", "vector still held", call_vec, exp_vec(2));
    do_ack();
    tick(4);
    check("R5", "no call after ack", call_cnt - c0, 0);
    clear_all();
  endtask

  // R2
  task automatic t_edges();
    logic [1:0] m;
    src_en = 5'h01; ext_route_en = 1; ext_dir_in = 1;
    for (int k = 0; k < 4; k++) begin
      m = 2'(k);
      @(negedge clk); ext_edge_sel = m;
      set_pin(1'b1);
      check("R2", $sformatf("rise mode %0d", k), flags_out[0], m[0]);
      clear_all();
      set_pin(1'b0);
      check("R2", $sformatf("fall mode %0d", k), flags_out[0], m[1]);
      clear_all();
    end
  endtask

  // R3
  task automatic t_ext_gate();
    ext_edge_sel = 2'b11;
    for (int k = 0; k < 3; k++) begin
      src_en = (k == 0) ? 5'h00 : 5'h01;
      ext_route_en = (k != 1);
      ext_dir_in   = (k != 2);
      set_pin(1'b1);
      set_pin(1'b0);
      check("R3", $sformatf("gated case %0d", k), flags_out[0], 1'b0);
    end
    src_en = 5'h00; ext_route_en = 1; ext_dir_in = 1;
  endtask

  // R4 serial events and disabled sources
  task automatic t_serial();
    src_en = 5'h00;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      ser_rx_done = (k == 0); ser_tx_done = (k == 1);
      ser_addr_hit = (k == 2); ser_timeout = (k == 3);
      @(negedge clk);
      ser_rx_done = 0; ser_tx_done = 0; ser_addr_hit = 0; ser_timeout = 0;
      tick(1);
      check("R4", $sformatf("serial event %0d", k), flags_out, 5'b01000);
      clear_all();
    end
    pulse_src(4);
    check("R4", "tick sets with enable off", flags_out, 5'b10000);
    clear_all();
  endtask

  // R10
  task automatic t_sw_clear();
    bit s; logic [7:0] v; int w;
    pulse_src(1);
    @(negedge clk); flag_clr = 5'b00010;
    @(negedge clk); flag_clr = 5'b00000;
    check("R10", "strobe clears", flags_out[1], 1'b0);
    @(negedge clk); flag_clr = 5'b00100; tmr_overflow = 1;
    @(negedge clk); flag_clr = 5'b00000; tmr_overflow = 0;
    check("R10", "set beats clear", flags_out[2], 1'b1);
    clear_all();
    src_en = 5'h1f;
    pulse_src(2);
    strobe_gie_set();
    wait_call(10, s, v, w);
    @(negedge clk); svc_ack = 1; tmr_overflow = 1;
    @(negedge clk); svc_ack = 0; tmr_overflow = 0;
    check("R10", "event beats ack clear", flags_out[2], 1'b1);
    check("R9", "gie cleared on ack", gie_out, 1'b0);
    clear_all();
  endtask

  // R11
  task automatic t_gie();
    bit s; logic [7:0] v; int w;
    strobe_gie_set();
    check("R11", "set", gie_out, 1'b1);
    @(negedge clk); gie_clr = 1;
    @(negedge clk); gie_clr = 0;
    check("R11", "clear", gie_out, 1'b0);
    @(negedge clk); gie_set = 1; gie_clr = 1;
    @(negedge clk); gie_set = 0; gie_clr = 0;
    check("R11", "clear beats set", gie_out, 1'b0);
    src_en = 5'h1f;
    pulse_src(4);
    wait_call(6, s, v, w);
    check("R11", "no call without gie", s, 1'b0);
    strobe_gie_set();
    wait_call(10, s, v, w);
    @(negedge clk); svc_ack = 1; gie_set = 1;
    @(negedge clk); svc_ack = 0; gie_set = 0;
    check("R11", "ack beats set", gie_out, 1'b0);
    check("R9", "tick flag cleared", flags_out[4], 1'b0);
  endtask

  initial begin
    rst_n = 0; ext_pin = 0; ext_edge_sel = 0; ext_route_en = 0; ext_dir_in = 0;
    ee_write_done = 0; tmr_overflow = 0; tbase_tick = 0;
    ser_rx_done = 0; ser_tx_done = 0; ser_addr_hit = 0; ser_timeout = 0;
    src_en = 0; flag_clr = 0; gie_set = 0; gie_clr = 0; stack_full = 0; svc_ack = 0;
    tick(3);
    t_reset();
    @(negedge clk); rst_n = 1;
    tick(2);
    t_reset();
    t_timer_call();
    t_vectors();
    t_priority();
    t_holdoff();
    t_busy();
    t_edges();
    t_ext_gate();
    t_serial();
    t_sw_clear();
    t_gie();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule